// File: doc/BRIEF.md
# Flash Block Controller

This block sits between a small CPU's data bus and an on-chip flash array of 128 blocks of 32 bytes each. The CPU sees four byte-wide registers, picked by a 2-bit selector: a block pointer, an offset pointer, a data window and a control/status register. Reading the data window returns the byte that the two pointers select. Writing the data window does not replace the stored byte. It merges the written value into it with a bitwise OR, which is how a flash cell can only ever be programmed. Erasing sets a whole block to zero.

The control register starts a block erase. It then shows a busy flag that stays up for a fixed, parameterised number of cycles. While the erase runs, the block pointer, the data window and further erase commands are locked out. A strobe advances the offset pointer by one, so that a serial loader can stream bytes straight into the array. When carry mode is on, moving past the last byte of a block also moves the block pointer to the next block. A separate strobe clears the whole array by sweeping it one block per cycle. This strobe is meant for entry into programming mode.

Top module: `flash_blk_ctrl`

## Requirements
- R1: After reset the block pointer and the offset pointer are 0, busy is low and the control register reads 0x00. The array contents are kept through reset.
- R2: The register selector works as follows. 0 is the block pointer, read back as a 7-bit value with bit 7 zero. 1 is the offset pointer, read back in bits 4:0 with the upper bits zero. 2 is the data window. 3 is control, where a read gives busy in bit 0 and zeros elsewhere.
- R3: When idle, a data-window read returns the byte at flat index block*32+offset. A byte that has been erased reads 0x00.
- R4: A data-window write while idle changes the selected byte to the OR of its old value and the written value. No other byte changes.
- R5: A control write with bit 0 set, made while idle, clears all 32 bytes of the selected block and holds busy high for exactly ERASE_CYCLES cycles. A control write with bit 0 clear does nothing, and other blocks are untouched.
- R6: While busy, writes to the block pointer, writes to the data window, erase commands and offset strobes have no effect, and data-window reads return 0x00.
- R7: An offset strobe while idle adds 1 to the offset pointer, wrapping from 31 to 0. With carry mode off, the block pointer does not change.
- R8: With carry mode on, a strobe at offset 31 also adds 1 to the block pointer, wrapping from 127 to 0.
- R9: A data write that comes in the same cycle as a strobe uses the address from before the increment. A register write to a pointer wins over the strobe's effect on that pointer.
- R10: The whole-array strobe, when idle, clears every block and holds busy for exactly 128 cycles. It wins over a control erase command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register selector (0 block, 1 offset, 2 data, 3 control) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| addr_inc | input | 1 | Offset pointer increment strobe |
| carry_en | input | 1 | Carry mode: offset rollover advances the block pointer |
| erase_all | input | 1 | Start a whole-array erase |
| busy | output | 1 | An erase is in progress |

## Verification
The hardest behaviour to observe is the forced zero on data reads while busy. A block erase clears the selected block first, so that block would read zero anyway. The bench therefore programs the last byte of the top block, starts a whole-array sweep and reads that byte in the very next cycle, when the sweep has not yet reached it. The lock-out of a second erase command is shown by issuing one partway through an erase and then checking that the busy window still lasts exactly ERASE_CYCLES cycles.

// File: rtl/flash_blk_pkg.sv
package flash_blk_pkg;
   typedef enum logic [1:0] {
      SEL_BLOCK  = 2'd0,
      SEL_OFFSET = 2'd1,
      SEL_DATA   = 2'd2,
      SEL_CTRL   = 2'd3
   } reg_sel_e;

   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_BUSY_BIT = 0;
endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
   parameter int BW     = 7,
   parameter int YW     = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic [BW+YW-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [BW+YW-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [BW-1:0]     clr_blk
);
   localparam int BYTES = 1 << YW;
   localparam int DEPTH = (1 << BW) * BYTES;

   logic [DATA_W-1:0] cells [DEPTH];

   // Programming can only set bits; clearing a block zeroes it
   always_ff @(posedge clk) begin
      if (wr_en)
         cells[wr_addr] <= cells[wr_addr] | wr_data;
      if (clr_en)
         for (int i = 0; i < BYTES; i++)
            cells[{clr_blk, YW'(i)}] <= '0;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/flash_addr_regs.sv
module flash_addr_regs #(
   parameter int BW            = 7,
   parameter int YW            = 5,
   parameter bit CARRY_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blk_we,
   input  logic [BW-1:0] blk_wdata,
   input  logic          ofs_we,
   input  logic [YW-1:0] ofs_wdata,
   input  logic          step,
   input  logic          carry_en,
   output logic [BW-1:0] blk_q,
   output logic [YW-1:0] ofs_q
);
   logic carry_ok;
   logic ofs_step;

   assign ofs_step = step && !ofs_we;

   generate
      if (CARRY_SUPPORT) begin : g_carry
         assign carry_ok = carry_en && ofs_step && (ofs_q == '1);
      end else begin : g_nocarry
         logic unused_carry;
         assign unused_carry = carry_en;
         assign carry_ok     = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= '0;
         ofs_q <= '0;
      end else begin
         if (ofs_we)
            ofs_q <= ofs_wdata;
         else if (ofs_step)
            ofs_q <= ofs_q + YW'(1);
         if (blk_we)
            blk_q <= blk_wdata;
         else if (carry_ok)
            blk_q <= blk_q + BW'(1);
      end
   end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
   parameter int BW           = 7,
   parameter int ERASE_CYCLES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_blk,
   input  logic          start_all,
   output logic          busy,
   output logic          sweep_en,
   output logic [BW-1:0] sweep_blk
);
   localparam int BLOCKS = 1 << BW;
   localparam int MAXC   = (ERASE_CYCLES > BLOCKS) ? ERASE_CYCLES : BLOCKS;
   localparam int CW     = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;
   logic          sweeping;

   assign busy     = (cnt != '0);
   assign sweep_en = sweeping && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sweeping  <= 1'b0;
         sweep_blk <= '0;
      end else if (!busy && start_all) begin
         cnt       <= CW'(BLOCKS);
         sweeping  <= 1'b1;
         sweep_blk <= '0;
      end else if (!busy && start_blk) begin
         cnt      <= CW'(ERASE_CYCLES);
         sweeping <= 1'b0;
      end else if (busy) begin
         cnt <= cnt - CW'(1);
         if (sweeping)
            sweep_blk <= sweep_blk + BW'(1);
      end
   end
endmodule

// File: rtl/flash_blk_ctrl.sv
module flash_blk_ctrl
   import flash_blk_pkg::*;
#(
   parameter int BLOCKS        = 128,
   parameter int BLOCK_BYTES   = 32,
   parameter int DATA_W        = 8,
   parameter int ERASE_CYCLES  = 64,
   parameter bit CARRY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              addr_inc,
   input  logic              carry_en,
   input  logic              erase_all,
   output logic              busy
);
   localparam int BW = $clog2(BLOCKS);
   localparam int YW = $clog2(BLOCK_BYTES);

   initial begin
      assert (BLOCKS >= 2 && (1 << BW) == BLOCKS)
         else $error("BLOCKS must be a power of two");
      assert (BLOCK_BYTES >= 2 && (1 << YW) == BLOCK_BYTES)
         else $error("BLOCK_BYTES must be a power of two");
      assert (DATA_W > BW && DATA_W > YW)
         else $error("DATA_W too narrow for address readback");
      assert (ERASE_CYCLES >= 1)
         else $error("ERASE_CYCLES must be positive");
   end

   reg_sel_e          sel;
   logic              hit_blk, hit_ofs, hit_data, hit_ctrl;
   logic              blk_we, ofs_we, data_we, step, go_blk;
   logic [BW-1:0]     blk_q, sweep_blk, clr_blk;
   logic [YW-1:0]     ofs_q;
   logic              sweep_en, clr_en;
   logic [DATA_W-1:0] cell_q;

   assign sel      = reg_sel_e'(reg_sel);
   assign hit_blk  = reg_wr && (sel == SEL_BLOCK);
   assign hit_ofs  = reg_wr && (sel == SEL_OFFSET);
   assign hit_data = reg_wr && (sel == SEL_DATA);
   assign hit_ctrl = reg_wr && (sel == SEL_CTRL);

   assign blk_we  = hit_blk && !busy;
   assign ofs_we  = hit_ofs;
   assign data_we = hit_data && !busy;
   assign step    = addr_inc && !busy;
   assign go_blk  = hit_ctrl && reg_wdata[CTRL_GO_BIT];

   assign clr_en  = sweep_en || (go_blk && !busy && !erase_all);
   assign clr_blk = sweep_en ? sweep_blk : blk_q;

   flash_addr_regs #(
      .BW(BW), .YW(YW), .CARRY_SUPPORT(CARRY_SUPPORT)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_we    (blk_we),
      .blk_wdata (reg_wdata[BW-1:0]),
      .ofs_we    (ofs_we),
      .ofs_wdata (reg_wdata[YW-1:0]),
      .step      (step),
      .carry_en  (carry_en),
      .blk_q     (blk_q),
      .ofs_q     (ofs_q)
   );

   flash_erase_timer #(
      .BW(BW), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_blk (go_blk),
      .start_all (erase_all),
      .busy      (busy),
      .sweep_en  (sweep_en),
      .sweep_blk (sweep_blk)
   );

   flash_cell_array #(
      .BW(BW), .YW(YW), .DATA_W(DATA_W)
   ) u_cells (
      .clk     (clk),
      .rd_addr ({blk_q, ofs_q}),
      .rd_data (cell_q),
      .wr_en   (data_we),
      .wr_addr ({blk_q, ofs_q}),
      .wr_data (reg_wdata),
      .clr_en  (clr_en),
      .clr_blk (clr_blk)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_BLOCK:  reg_rdata = {{(DATA_W-BW){1'b0}}, blk_q};
         SEL_OFFSET: reg_rdata = {{(DATA_W-YW){1'b0}}, ofs_q};
         SEL_DATA:   reg_rdata = busy ? '0 : cell_q;
         SEL_CTRL:   reg_rdata[CTRL_BUSY_BIT] = busy;
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/flash_blk_ctrl_chk.sv
module flash_blk_ctrl_chk #(
   parameter int BW     = 7,
   parameter int YW     = 5,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        reg_sel,
   input logic              reg_wr,
   input logic              go_bit,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              addr_inc,
   input logic              erase_all,
   input logic              busy,
   input logic [BW-1:0]     blk_q,
   input logic [YW-1:0]     ofs_q
);
   // R2
   ctrl_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd3) |-> (reg_rdata == DATA_W'(busy)));

   // R5
   erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (erase_all || (reg_wr && reg_sel == 2'd3 && go_bit))) |=> busy);

   // R6
   blk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(blk_q));

   // R6
   data_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_sel == 2'd2) |-> (reg_rdata == '0));

   // R7
   offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_inc && !busy && !(reg_wr && reg_sel == 2'd1))
      |=> (ofs_q == YW'($past(ofs_q) + 1'b1)));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!busy || rst_n));
endmodule

bind flash_blk_ctrl flash_blk_ctrl_chk #(
   .BW(BW), .YW(YW), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_wr    (reg_wr),
   .go_bit    (reg_wdata[0]),
   .reg_rdata (reg_rdata),
   .addr_inc  (addr_inc),
   .erase_all (erase_all),
   .busy      (busy),
   .blk_q     (blk_q),
   .ofs_q     (ofs_q)
);

// File: tb/flash_blk_ctrl_test.sv
module flash_blk_ctrl_test;
   localparam int ERASE_CYCLES = 64;
   localparam int BLOCKS       = 128;
   localparam int NV           = 21;

   // {sel[1:0], write, wdata[7:0], expected read[7:0]}
   localparam logic [18:0] VEC [NV] = '{
      {2'd0, 1'b1, 8'h05, 8'h00},
      {2'd1, 1'b1, 8'h03, 8'h00},
      {2'd2, 1'b0, 8'h00, 8'h00},
      {2'd2, 1'b1, 8'h12, 8'h00},
      {2'd2, 1'b0, 8'h00, 8'h12},
      {2'd2, 1'b1, 8'h41, 8'h00},
      {2'd2, 1'b0, 8'h00, 8'h53},
      {2'd0, 1'b0, 8'h00, 8'h05},
      {2'd1, 1'b0, 8'h00, 8'h03},
      {2'd3, 1'b0, 8'h00, 8'h00},
      {2'd1, 1'b1, 8'h04, 8'h00},
      {2'd2, 1'b0, 8'h00, 8'h00},
      {2'd0, 1'b1, 8'h7F, 8'h00},
      {2'd1, 1'b1, 8'h1F, 8'h00},
      {2'd2, 1'b1, 8'hFF, 8'h00},
      {2'd2, 1'b0, 8'h00, 8'hFF},
      {2'd0, 1'b1, 8'h05, 8'h00},
      {2'd1, 1'b1, 8'h03, 8'h00},
      {2'd2, 1'b0, 8'h00, 8'h53},
      {2'd0, 1'b1, 8'h85, 8'h00},
      {2'd0, 1'b0, 8'h00, 8'h05}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       addr_inc = 1'b0;
   logic       carry_en = 1'b0;
   logic       erase_all = 1'b0;
   logic       busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   flash_blk_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_inc(addr_inc),
      .carry_en(carry_en), .erase_all(erase_all), .busy(busy)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp,
                        input string req, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_rd(input logic [1:0] s, input logic [7:0] exp,
                           input string req, input string what);
      reg_sel = s;
      #1;
      check(reg_rdata, exp, req, what);
   endtask

   task automatic do_wr(input logic [1:0] s, input logic [7:0] d, input logic inc);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1; addr_inc = inc;
      @(negedge clk);
      reg_wr = 1'b0; addr_inc = 1'b0;
   endtask

   task automatic do_inc();
      addr_inc = 1'b1;
      @(negedge clk);
      addr_inc = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 1;
      forever begin
         @(negedge clk);
         if (!busy) break;
         n++;
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_rd(2'd0, 8'h00, "R1", "block pointer after reset");
      check_rd(2'd1, 8'h00, "R1", "offset pointer after reset");
      check_rd(2'd3, 8'h00, "R1", "control after reset");
      check({7'd0, busy}, 8'h00, "R1", "busy after reset");

      // start from a clean array
      erase_all = 1'b1;
      @(negedge clk);
      erase_all = 1'b0;
      busy_len(n);

      // vector walk: R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][16])
            do_wr(VEC[i][18:17], VEC[i][15:8], 1'b0);
         else
            check_rd(VEC[i][18:17], VEC[i][7:0], "R2/R3/R4", $sformatf("vector %0d", i));
      end

      // R5 block erase; bit 0 clear does nothing
      do_wr(2'd3, 8'hFE, 1'b0);
      check({7'd0, busy}, 8'h00, "R5", "control write with go bit clear");
      do_wr(2'd3, 8'h01, 1'b0);
      check({7'd0, busy}, 8'h01, "R5", "busy after erase command");
      check_rd(2'd3, 8'h01, "R2", "control busy bit");
      // R6 lock-out during erase
      do_wr(2'd0, 8'h09, 1'b0);
      do_wr(2'd2, 8'hAA, 1'b0);
      do_inc();
      do_wr(2'd3, 8'h01, 1'b0);
      check_rd(2'd0, 8'h05, "R6", "block write ignored while busy");
      check_rd(2'd1, 8'h03, "R6", "offset strobe ignored while busy");
      check_rd(2'd2, 8'h00, "R6", "data read while busy");
      busy_len(n);
      n = n + 4;
      check(8'(n), 8'(ERASE_CYCLES), "R5", "erase busy length, restart ignored (R6)");
      check_rd(2'd2, 8'h00, "R5", "erased block byte");
      do_wr(2'd0, 8'h7F, 1'b0);
      do_wr(2'd1, 8'h1F, 1'b0);
      check_rd(2'd2, 8'hFF, "R5", "other block untouched");

      // R7 offset strobe without carry
      carry_en = 1'b0;
      do_wr(2'd0, 8'h02, 1'b0);
      do_wr(2'd1, 8'd30, 1'b0);
      do_inc();
      check_rd(2'd1, 8'd31, "R7", "offset step");
      do_inc();
      check_rd(2'd1, 8'd0, "R7", "offset wrap");
      check_rd(2'd0, 8'h02, "R7", "block unchanged without carry");

      // R8 carry into block pointer
      carry_en = 1'b1;
      do_wr(2'd1, 8'd31, 1'b0);
      do_inc();
      check_rd(2'd0, 8'h03, "R8", "carry into block");
      check_rd(2'd1, 8'h00, "R8", "offset after carry");
      do_wr(2'd0, 8'h7F, 1'b0);
      do_wr(2'd1, 8'd31, 1'b0);
      do_inc();
      check_rd(2'd0, 8'h00, "R8", "block wrap on carry");
      carry_en = 1'b0;

      // R9 streaming write with strobe, and register priority
      do_wr(2'd0, 8'd10, 1'b0);
      do_wr(2'd1, 8'd0, 1'b0);
      do_wr(2'd2, 8'h11, 1'b1);
      do_wr(2'd2, 8'h22, 1'b1);
      check_rd(2'd1, 8'd2, "R9", "offset after two streamed bytes");
      do_wr(2'd1, 8'd0, 1'b0);
      check_rd(2'd2, 8'h11, "R9", "streamed byte 0");
      do_wr(2'd1, 8'd1, 1'b0);
      check_rd(2'd2, 8'h22, "R9", "streamed byte 1");
      do_wr(2'd1, 8'd7, 1'b1);
      check_rd(2'd1, 8'd7, "R9", "offset write beats strobe");
      carry_en = 1'b1;
      do_wr(2'd1, 8'd31, 1'b0);
      do_wr(2'd0, 8'd20, 1'b1);
      check_rd(2'd0, 8'd20, "R9", "block write beats carry");
      check_rd(2'd1, 8'd0, "R9", "offset still steps");
      carry_en = 1'b0;

      // R10 whole-array sweep, wins over same-cycle control erase
      do_wr(2'd0, 8'h7F, 1'b0);
      do_wr(2'd1, 8'h1F, 1'b0);
      check_rd(2'd2, 8'hFF, "R10", "byte present before sweep");
      reg_sel = 2'd3; reg_wdata = 8'h01; reg_wr = 1'b1; erase_all = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; erase_all = 1'b0;
      check_rd(2'd2, 8'h00, "R6", "data masked before sweep reaches block");
      busy_len(n);
      check(8'(n), 8'(BLOCKS), "R10", "sweep busy length");
      check_rd(2'd2, 8'h00, "R10", "top block cleared");
      do_wr(2'd0, 8'd10, 1'b0);
      do_wr(2'd1, 8'd0, 1'b0);
      check_rd(2'd2, 8'h00, "R10", "block 10 cleared");

      // R1 reset mid-run, contents kept
      do_wr(2'd2, 8'h5A, 1'b0);
      do_wr(2'd0, 8'd6, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check_rd(2'd0, 8'h00, "R1", "block pointer in reset");
      rst_n = 1'b1;
      @(negedge clk);
      do_wr(2'd0, 8'd10, 1'b0);
      check_rd(2'd2, 8'h5A, "R1", "array kept through reset");

      done = 1'b1;
      report();
      $finish;
   end
endmodule